// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pins (64 or 96, a whole number of 32-bit words). Software reaches it through a plain register bus with a byte address, write data, a write strobe, a read strobe and registered read data. Each pin gets an output-enable bit, an output latch driven through separate write-one-to-set and write-one-to-clear words, a synchronised level readback, and independent rising and falling edge enables. A two-bit function selector per pin is also held here and driven out to the pad ring.

Edges seen on enabled pins are latched into sticky status bits that stay set until software writes a one to them. An edge that arrives in the same cycle as its clear is kept, so none is lost. The single interrupt output is high while any status bit is pending.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: With NREG = NPINS/32, the register at byte address 4*(g*NREG + w) is word w (pins 32w..32w+31, pin p at bit p mod 32) of group g. The group order is g=0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status, 7 function select. The function group holds 2*NREG words. Address bits [1:0] are ignored. Both NPINS=64 and NPINS=96 are supported.
- R2: After reset, pin_oe, pin_out, func_sel, irq and bus_rdata are zero, and every direction, enable, status and function-select register reads zero.
- R3: Writing the set group ORs the write data into the output latch words. Writing the clear group removes the written one bits. Zero bits leave the latch unchanged. pin_out shows the latch from the cycle after the write.
- R4: A direction bit of 1 drives the matching pin_oe bit high (output) and 0 drives it low (input). The group reads back as written.
- R5: A level read returns pin_in after a two-flop synchroniser. A change on pin_in is readable two clock edges later. bus_rdata is loaded on the edge where bus_re is high and holds otherwise.
- R6: A status bit sets one edge after the synchronised level rises while that pin's rising enable is 1, or falls while its falling enable is 1. Both enables may be set at once. Pins without an enable never set status.
- R7: Status bits are sticky and clear only when a one is written to them. If an edge is detected in the same cycle as the clear, the bit stays set.
- R8: Function-select word k holds pins 16k..16k+15, two bits per pin, with pin p at bits [2(p mod 16)+1 : 2(p mod 16)]. func_sel[2p+1:2p] carries the same value. It reads back as written, and 0 means plain GPIO.
- R9: Writes to the level group and to addresses past the last group change nothing. Reads of the set group, the clear group and out-of-range addresses return zero.
- R10: irq is high exactly while at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Pad input levels |
| pin_oe | output | NPINS | Output enables (direction) |
| pin_out | output | NPINS | Output latch values |
| func_sel | output | 2*NPINS | Two-bit function selector per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
Assertions check on every cycle that set and clear writes merge into the output latch as a bitwise OR and AND-NOT. They also check that direction and function-select writes appear at the outputs one cycle later, that level-group writes leave every output untouched, and that a pending interrupt cannot drop without a bus write. Edge timing through the synchroniser, the choice between rising and falling enables, the survival of an edge that meets its own clear, and the zero read-back of write-only and unmapped addresses depend on timed pin stimulus. Only the bench scenarios show those, against a cycle-by-cycle reference model.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  localparam int WORD_W   = 32;
  localparam int NUM_FEAT = 8;

  // Group order is part of the address map.
  typedef enum logic [2:0] {
    FEAT_LEVEL   = 3'd0,
    FEAT_DIR     = 3'd1,
    FEAT_SET     = 3'd2,
    FEAT_CLR     = 3'd3,
    FEAT_RISE_EN = 3'd4,
    FEAT_FALL_EN = 3'd5,
    FEAT_STATUS  = 3'd6,
    FEAT_ALT     = 3'd7
  } feat_e;

  typedef struct packed {
    logic       hit;
    feat_e      feat;
    logic [7:0] idx;
  } dec_t;
endpackage

// File: rtl/gpio_rst_sync.sv
`timescale 1ns/1ps
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/gpio_addr_decode.sv
`timescale 1ns/1ps
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int NREG   = 2,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam int WA = ADDR_W - 2;

  logic [WA-1:0] word;
  logic          unused_lsb;

  assign word       = addr[ADDR_W-1:2];
  assign unused_lsb = ^addr[1:0];

  // Range compare per group; the function group spans twice the words.
  always_comb begin
    dec = '0;
    for (int f = 0; f < NUM_FEAT; f++) begin
      if ((int'(word) >= f * NREG) &&
          (int'(word) < f * NREG + ((f == NUM_FEAT - 1) ? 2 * NREG : NREG))) begin
        dec.hit  = 1'b1;
        dec.feat = feat_e'(3'(f));
        dec.idx  = 8'(int'(word) - f * NREG);
      end
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level = sync_q;
  assign rise  = sync_q & ~prev_q;
  assign fall  = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_edge_latch.sv
`timescale 1ns/1ps
module gpio_edge_latch #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rise,
  input  logic [N-1:0] fall,
  input  logic [N-1:0] rise_en,
  input  logic [N-1:0] fall_en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] status
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic st_q, st_d;

    // A new edge wins over a clear in the same cycle.
    always_comb begin
      st_d = (st_q & ~clr[i]) | (rise[i] & rise_en[i]) | (fall[i] & fall_en[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= 1'b0;
      else        st_q <= st_d;
    end

    assign status[i] = st_q;
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
`timescale 1ns/1ps
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 64,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_we,
  input  logic                 bus_re,
  output logic [31:0]          bus_rdata,
  input  logic [NPINS-1:0]     pin_in,
  output logic [NPINS-1:0]     pin_oe,
  output logic [NPINS-1:0]     pin_out,
  output logic [2*NPINS-1:0]   func_sel,
  output logic                 irq
);
  localparam int NREG = NPINS / WORD_W;
  localparam int BW   = $clog2(2 * NPINS);

  logic rst_core_n;
  dec_t dec;
  logic [BW-1:0] wbase;
  logic          wr_hit;

  logic [NPINS-1:0]   dir_q, dir_d, out_q, out_d;
  logic [NPINS-1:0]   ren_q, ren_d, fen_q, fen_d;
  logic [2*NPINS-1:0] alt_q, alt_d;
  logic [NPINS-1:0]   clr_mask, level, rise, fall, status;
  logic [31:0]        rd_val, rdata_q, rdata_d;

  gpio_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_core_n)
  );

  gpio_addr_decode #(.NREG(NREG), .ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  gpio_in_sync #(.N(NPINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .pin_in (pin_in),
    .level  (level),
    .rise   (rise),
    .fall   (fall)
  );

  gpio_edge_latch #(.N(NPINS)) u_edge (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .rise    (rise),
    .fall    (fall),
    .rise_en (ren_q),
    .fall_en (fen_q),
    .clr     (clr_mask),
    .status  (status)
  );

  assign wbase  = BW'(dec.idx) << 5;
  assign wr_hit = bus_we & dec.hit;

  // Register next state
  always_comb begin
    dir_d    = dir_q;
    out_d    = out_q;
    ren_d    = ren_q;
    fen_d    = fen_q;
    alt_d    = alt_q;
    clr_mask = '0;
    if (wr_hit) begin
      case (dec.feat)
        FEAT_DIR:     dir_d[wbase +: 32]    = bus_wdata;
        FEAT_SET:     out_d[wbase +: 32]    = out_q[wbase +: 32] | bus_wdata;
        FEAT_CLR:     out_d[wbase +: 32]    = out_q[wbase +: 32] & ~bus_wdata;
        FEAT_RISE_EN: ren_d[wbase +: 32]    = bus_wdata;
        FEAT_FALL_EN: fen_d[wbase +: 32]    = bus_wdata;
        FEAT_STATUS:  clr_mask[wbase +: 32] = bus_wdata;
        FEAT_ALT:     alt_d[wbase +: 32]    = bus_wdata;
        default:      ;
      endcase
    end
  end

  // Read multiplexer
  always_comb begin
    rd_val = '0;
    if (dec.hit) begin
      case (dec.feat)
        FEAT_LEVEL:   rd_val = level[wbase +: 32];
        FEAT_DIR:     rd_val = dir_q[wbase +: 32];
        FEAT_RISE_EN: rd_val = ren_q[wbase +: 32];
        FEAT_FALL_EN: rd_val = fen_q[wbase +: 32];
        FEAT_STATUS:  rd_val = status[wbase +: 32];
        FEAT_ALT:     rd_val = alt_q[wbase +: 32];
        default:      rd_val = '0;
      endcase
    end
    rdata_d = bus_re ? rd_val : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      ren_q   <= '0;
      fen_q   <= '0;
      alt_q   <= '0;
      rdata_q <= '0;
    end else begin
      dir_q   <= dir_d;
      out_q   <= out_d;
      ren_q   <= ren_d;
      fen_q   <= fen_d;
      alt_q   <= alt_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign pin_oe    = dir_q;
  assign pin_out   = out_q;
  assign func_sel  = alt_q;
  assign irq       = |status;
endmodule

// File: rtl/gpio_bank_chk.sv
`timescale 1ns/1ps
module gpio_bank_chk #(
  parameter int NPINS  = 64,
  parameter int ADDR_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic               bus_we,
  input logic [NPINS-1:0]   pin_oe,
  input logic [NPINS-1:0]   pin_out,
  input logic [2*NPINS-1:0] func_sel,
  input logic               irq
);
  localparam int NREG = NPINS / 32;
  localparam int WA   = ADDR_W - 2;

  logic [WA-1:0] word;
  logic          unused_lsb;
  assign word       = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];

  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && word == WA'(2 * NREG)) |=>
      pin_out[31:0] == ($past(pin_out[31:0]) | $past(bus_wdata)));

  assert_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && word == WA'(3 * NREG)) |=>
      pin_out[31:0] == ($past(pin_out[31:0]) & ~$past(bus_wdata)));

  assert_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && word == WA'(NREG)) |=> pin_oe[31:0] == $past(bus_wdata));

  assert_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !bus_we) |=> irq);

  assert_alt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && word == WA'(7 * NREG)) |=> func_sel[31:0] == $past(bus_wdata));

  assert_level_ro_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && word == '0) |=>
      ($stable(pin_out) && $stable(pin_oe) && $stable(func_sel)));
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .func_sel  (func_sel),
  .irq       (irq)
);

// File: tb/sim_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_bank_ctrl;
  localparam int NP   = 96;
  localparam int NREG = NP / 32;
  localparam int AW   = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic bus_we, bus_re;
  logic [NP-1:0] pin_in, pin_oe, pin_out;
  logic [2*NP-1:0] func_sel;
  logic irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  gpio_bank_ctrl #(.NPINS(NP), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .func_sel(func_sel), .irq(irq)
  );

  // Reference model state
  logic m_rs1, m_rs2;
  logic [NP-1:0] m_s1, m_s2, m_prev, m_dir, m_out, m_ren, m_fen, m_st;
  logic [2*NP-1:0] m_af;
  logic [31:0] m_rdata;
  string m_rtag = "R2";

  task automatic model_clear();
    m_s1 = '0; m_s2 = '0; m_prev = '0; m_dir = '0; m_out = '0;
    m_ren = '0; m_fen = '0; m_st = '0; m_af = '0; m_rdata = '0;
  endtask

  task automatic model_step();
    logic [NP-1:0] rise, fall, ev, clr;
    logic [31:0] rv;
    int word, f, ix;
    bit ok;
    if (!rst_n) begin
      model_clear();
      m_rs1 = 0; m_rs2 = 0;
      return;
    end
    if (!m_rs2) begin
      model_clear();
    end else begin
      rise = m_s2 & ~m_prev;
      fall = ~m_s2 & m_prev;
      ev   = (rise & m_ren) | (fall & m_fen);
      word = int'(bus_addr) / 4;
      f = word / NREG; ix = word % NREG; ok = 1;
      if (f >= 7) begin
        f = 7; ix = word - 7 * NREG; ok = (ix < 2 * NREG);
      end
      rv = 0; clr = '0;
      if (ok) begin
        case (f)
          0: rv = m_s2[ix*32 +: 32];
          1: rv = m_dir[ix*32 +: 32];
          4: rv = m_ren[ix*32 +: 32];
          5: rv = m_fen[ix*32 +: 32];
          6: rv = m_st[ix*32 +: 32];
          7: rv = m_af[ix*32 +: 32];
          default: rv = 0;
        endcase
      end
      if (bus_we && ok) begin
        case (f)
          1: m_dir[ix*32 +: 32] = bus_wdata;
          2: m_out[ix*32 +: 32] = m_out[ix*32 +: 32] | bus_wdata;
          3: m_out[ix*32 +: 32] = m_out[ix*32 +: 32] & ~bus_wdata;
          4: m_ren[ix*32 +: 32] = bus_wdata;
          5: m_fen[ix*32 +: 32] = bus_wdata;
          6: clr[ix*32 +: 32]   = bus_wdata;
          7: m_af[ix*32 +: 32]  = bus_wdata;
          default: ;
        endcase
      end
      m_st = (m_st & ~clr) | ev;
      if (bus_re) begin
        m_rdata = rv;
        if (!ok) m_rtag = "R9";
        else case (f)
          0: m_rtag = "R5";
          1: m_rtag = "R4";
          2, 3: m_rtag = "R9";
          4, 5: m_rtag = "R6";
          6: m_rtag = "R7";
          default: m_rtag = "R8";
        endcase
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
    m_rs2 = m_rs1; m_rs1 = 1;
  endtask

  task automatic cmp(logic [191:0] got, logic [191:0] exp, string tag, string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    cmp(192'(pin_out), 192'(m_out), "R3", "pin_out");
    cmp(192'(pin_oe), 192'(m_dir), "R4", "pin_oe");
    cmp(func_sel, m_af, "R8", "func_sel");
    cmp(192'(irq), 192'(m_st != '0), "R10", "irq");
    cmp(192'(bus_rdata), 192'(m_rdata), m_rtag, "bus_rdata (R1 map)");
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(int word, logic [31:0] d);
    bus_addr = AW'(word * 4); bus_wdata = d; bus_we = 1;
    tick();
    bus_we = 0; bus_wdata = '0;
  endtask

  task automatic rd(int word, logic [31:0] exp, string tag);
    bus_addr = AW'(word * 4); bus_re = 1;
    tick();
    bus_re = 0;
    cmp(192'(bus_rdata), 192'(exp), tag, "explicit read");
  endtask

  localparam int W_LVL = 0, W_DIR = NREG, W_SET = 2*NREG, W_CLR = 3*NREG;
  localparam int W_REN = 4*NREG, W_FEN = 5*NREG, W_ST = 6*NREG, W_ALT = 7*NREG;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_addr = '0; bus_wdata = '0; bus_we = 0; bus_re = 0; pin_in = '0;
    m_rs1 = 0; m_rs2 = 0; model_clear();
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();

    // R2 reset state
    cmp(192'(pin_oe), 0, "R2", "pin_oe after reset");
    cmp(192'(irq), 0, "R2", "irq after reset");
    rd(W_ST, 0, "R2");
    rd(W_ALT + 5, 0, "R2");

    // R4 direction
    wr(W_DIR + 0, 32'hA5A5_0F0F);
    wr(W_DIR + 2, 32'h8000_0001);
    rd(W_DIR + 2, 32'h8000_0001, "R4");
    cmp(192'(pin_oe[95]), 1, "R4", "pin_oe[95]");

    // R3 set / clear
    wr(W_SET + 0, 32'hF0F0_0001);
    wr(W_CLR + 0, 32'h0000_0001);
    wr(W_SET + 2, 32'h8000_0000);
    wr(W_SET + 0, 32'h0000_0000);
    cmp(192'(pin_out[95]), 1, "R3", "pin_out[95]");
    cmp(192'(pin_out[31:0]), 192'(32'hF0F0_0000), "R3", "pin_out word0");
    rd(W_SET, 0, "R9");
    rd(W_CLR + 1, 0, "R9");

    // R9 ignored writes
    wr(W_LVL, 32'hFFFF_FFFF);
    wr(9 * NREG, 32'hFFFF_FFFF);
    wr(60, 32'hFFFF_FFFF);
    cmp(192'(pin_out[31:0]), 192'(32'hF0F0_0000), "R9", "pin_out after ignored");
    rd(9 * NREG, 0, "R9");
    rd(W_DIR, 32'hA5A5_0F0F, "R9");

    // R5 level readback with address low bits set (R1)
    pin_in = {32'h1234_5678, 32'hCAFE_0000, 32'h0000_0000};
    repeat (3) tick();
    bus_addr = AW'(W_LVL * 4 + 4 + 3); bus_re = 1; tick(); bus_re = 0;
    cmp(192'(bus_rdata), 192'(32'hCAFE_0000), "R5", "level word1 (R1 low bits)");
    rd(W_LVL + 2, 32'h1234_5678, "R5");
    pin_in = '0;
    repeat (4) tick();

    // R6 edge detection
    wr(W_REN, 32'h0000_000F);
    wr(W_FEN, 32'h0000_00F0);
    pin_in[7:0] = 8'h0F; repeat (4) tick();
    rd(W_ST, 32'h0000_000F, "R6");
    cmp(192'(irq), 1, "R10", "irq pending");
    pin_in[7:0] = 8'hF0; repeat (4) tick();
    rd(W_ST, 32'h0000_000F, "R6");
    pin_in[7:0] = 8'h00; repeat (4) tick();
    rd(W_ST, 32'h0000_00FF, "R6");

    // R7 write-one-to-clear and collision
    wr(W_ST, 32'h0000_000F);
    rd(W_ST, 32'h0000_00F0, "R7");
    wr(W_REN + 1, 32'h0000_0100);
    wr(W_FEN + 1, 32'h0000_0100);
    pin_in[40] = 1; repeat (4) tick();
    rd(W_ST + 1, 32'h0000_0100, "R6");
    pin_in[40] = 0; tick(); tick();
    wr(W_ST + 1, 32'h0000_0100);
    rd(W_ST + 1, 32'h0000_0100, "R7");
    wr(W_ST + 1, 32'h0000_0100);
    rd(W_ST + 1, 0, "R7");
    wr(W_ST, 32'h0000_00FF);
    tick();
    cmp(192'(irq), 0, "R10", "irq cleared");

    // R8 function select
    wr(W_ALT + 0, 32'h0000_000C);
    wr(W_ALT + 5, 32'h4000_0000);
    cmp(192'(func_sel[3:2]), 3, "R8", "pin1 select");
    cmp(192'(func_sel[191:190]), 1, "R8", "pin95 select");
    rd(W_ALT + 5, 32'h4000_0000, "R8");
    repeat (3) tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule